// File: doc/BRIEF.md
# Wheel-Pulse Odometer with Two Trip Meters

This block turns the pulses of a wheel sensor into distance readings. It keeps three accumulators side by side: a six-digit total and two four-digit trip meters, trip A and trip B. Each accumulator holds a 16-bit raw pulse count and a row of BCD digits. The least significant digit steps at a fixed set of raw counts inside one window of the high byte. At the end of that window the raw count drops back to a non-zero preset, so one window covers a fixed stretch of road.

The block also passes a thinned copy of the sensor pulses on to a tachometer. Three pulses out of every four are sent on and the fourth is held back. A view register chooses which accumulator goes out on the digit bus. A short press moves to the next view. A long press clears the trip meter on show and does nothing while the total is on show. The press signals come from a button classifier outside this block and are one-cycle strobes.

Top module: `odometer`

## Requirements
- R1: `sense_n` is active low. It passes through a two-flop synchroniser, and each high-to-low transition of the synchronised level counts as exactly one pulse, however long the level then stays low.
- R2: Every accumulator has a 16-bit raw counter that goes up by one on each pulse. All three accumulators count every pulse, whatever the view.
- R3: After the increment, if the high byte equals WINDOW_HI (default 17) and the low byte equals STEP_BASE + k*STEP_GAP for k = 0 to STEP_COUNT-1 (defaults 0x28, 0x28 and 6, so 0x28 to 0xF0), the least significant digit of that accumulator steps by one.
- R4: Digits are BCD, one nibble each, with digit 0 in bits [3:0]. A digit at 9 goes to 0 and carries one into the next more significant digit.
- R5: After the increment, if the high byte equals WINDOW_HI and the low byte equals WRAP_LO (default 0xFE), the raw counter is loaded with RELOAD (default 83, high byte zero).
- R6: `tacho_out` counts pulses in groups of four from reset. The first three pulses of each group set it high and the fourth pulse leaves it low.
- R7: `tacho_out` goes high two clock edges after the edge that first samples `sense_n` low. It returns low one edge after the synchronised level is back high.
- R8: `view` encodes 0 = total, 1 = trip A, 2 = trip B. Each `short_press` strobe moves it 0 to 1, 1 to 2 and 2 to 0.
- R9: A `long_press` strobe in view 1 or 2 loads that trip's raw counter with RELOAD and clears its digits. In view 0 it changes neither a counter nor the view.
- R10: `disp_digits` is registered. It shows the six total digits in view 0. In views 1 and 2 it shows the trip digits in bits [15:0] and 8'hFF in bits [23:16]. It follows the state with one cycle of lag.
- R11: When a long press clears a trip in the same cycle as a pulse, the clear wins and that pulse is not counted on that trip.
- R12: Reset is synchronous and active high. It leaves every digit at zero, every raw counter at RELOAD, the view at 0, `tacho_out` low and the group position at its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sense_n | input | 1 | Wheel sensor, low while a pulse is present |
| short_press | input | 1 | One-cycle strobe: step to the next view |
| long_press | input | 1 | One-cycle strobe: clear the trip on show |
| disp_digits | output | 24 | BCD digits of the selected accumulator |
| view | output | 2 | Current view: 0 total, 1 trip A, 2 trip B |
| tacho_out | output | 1 | Thinned pulse for the tachometer |

## Verification
The assertions assume the button classifier never raises `short_press` and `long_press` in the same cycle. They also assume `sense_n` stays high while reset is held, so that the latency checks on `tacho_out` count from a clean idle level. The stimulus keeps to both rules. Presses come one at a time with idle cycles between them, and every sensor pulse is at least two cycles low and three cycles high. The one deliberate overlap puts a long press on the very edge where a pulse is counted, and it still keeps the two press strobes apart.

// File: rtl/odo_pkg.sv
package odo_pkg;
  typedef enum logic [1:0] {
    VIEW_TOTAL  = 2'd0,
    VIEW_TRIP_A = 2'd1,
    VIEW_TRIP_B = 2'd2
  } view_t;

  localparam int NIB_W = 4;
endpackage

// File: rtl/odo_sync_edge.sv
module odo_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign level = chain[STAGES-1];
  assign fall  = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/odo_tacho.sv
module odo_tacho #(
  parameter int GROUP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fall,
  input  logic level,
  output logic tacho
);
  localparam int SW = (GROUP > 2) ? $clog2(GROUP) : 1;
  localparam logic [SW-1:0] LAST = SW'(GROUP - 1);

  logic [SW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      tacho <= 1'b0;
    end else if (fall) begin
      if (pos == LAST) begin
        pos <= '0;
      end else begin
        pos   <= pos + 1'b1;
        tacho <= 1'b1;
      end
    end else if (level) begin
      tacho <= 1'b0;
    end
  end
endmodule

// File: rtl/odo_accum.sv
module odo_accum #(
  parameter int DIGITS     = 6,
  parameter int WINDOW_HI  = 17,
  parameter int STEP_BASE  = 'h28,
  parameter int STEP_GAP   = 'h28,
  parameter int STEP_COUNT = 6,
  parameter int WRAP_LO    = 'hFE,
  parameter int RELOAD     = 83
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bump,
  input  logic                  clear,
  output logic [DIGITS*4-1:0]   digits
);
  localparam logic [7:0]  WIN_B  = 8'(WINDOW_HI);
  localparam logic [7:0]  WRAP_B = 8'(WRAP_LO);
  localparam logic [15:0] LOAD_V = 16'(RELOAD);

  logic [15:0]         raw;
  logic [15:0]         raw_inc;
  logic                hit;
  logic                wrap;
  logic [DIGITS*4-1:0] dig_next;
  logic [DIGITS-1:0]   cy;

  assign raw_inc = raw + 16'd1;
  assign wrap    = (raw_inc[15:8] == WIN_B) && (raw_inc[7:0] == WRAP_B);

  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < STEP_COUNT; k++) begin
      if ((raw_inc[15:8] == WIN_B) && (raw_inc[7:0] == 8'(STEP_BASE + k * STEP_GAP)))
        hit = 1'b1;
    end
  end

  assign cy[0] = 1'b1;
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] cur;
    assign cur = digits[g*4 +: 4];
    assign dig_next[g*4 +: 4] = cy[g] ? ((cur == 4'd9) ? 4'd0 : cur + 4'd1) : cur;
    if (g < DIGITS - 1) begin : g_cy
      assign cy[g+1] = cy[g] & (cur == 4'd9);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      raw    <= LOAD_V;
      digits <= '0;
    end else if (bump) begin
      raw <= wrap ? LOAD_V : raw_inc;
      if (hit) digits <= dig_next;
    end
  end
endmodule

// File: rtl/odometer.sv
module odometer
  import odo_pkg::*;
#(
  parameter int TOTAL_DIGITS = 6,
  parameter int TRIP_DIGITS  = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int TACHO_GROUP  = 4,
  parameter int WINDOW_HI    = 17,
  parameter int STEP_BASE    = 'h28,
  parameter int STEP_GAP     = 'h28,
  parameter int STEP_COUNT   = 6,
  parameter int WRAP_LO      = 'hFE,
  parameter int RELOAD       = 83
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sense_n,
  input  logic                      short_press,
  input  logic                      long_press,
  output logic [TOTAL_DIGITS*4-1:0] disp_digits,
  output logic [1:0]                view,
  output logic                      tacho_out
);
  localparam int DW     = TOTAL_DIGITS * NIB_W;
  localparam int TW     = TRIP_DIGITS * NIB_W;
  localparam int FILL_W = DW - TW;

  view_t         view_q;
  logic          lvl;
  logic          pulse;
  logic          clr_a;
  logic          clr_b;
  logic [DW-1:0] tot_d;
  logic [TW-1:0] a_d;
  logic [TW-1:0] b_d;

  odo_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(sense_n), .level(lvl), .fall(pulse)
  );

  odo_tacho #(.GROUP(TACHO_GROUP)) u_tacho (
    .clk(clk), .rst(rst), .fall(pulse), .level(lvl), .tacho(tacho_out)
  );

  assign clr_a = long_press && (view_q == VIEW_TRIP_A);
  assign clr_b = long_press && (view_q == VIEW_TRIP_B);

  odo_accum #(
    .DIGITS(TOTAL_DIGITS), .WINDOW_HI(WINDOW_HI), .STEP_BASE(STEP_BASE),
    .STEP_GAP(STEP_GAP), .STEP_COUNT(STEP_COUNT), .WRAP_LO(WRAP_LO), .RELOAD(RELOAD)
  ) u_total (
    .clk(clk), .rst(rst), .bump(pulse), .clear(1'b0), .digits(tot_d)
  );

  odo_accum #(
    .DIGITS(TRIP_DIGITS), .WINDOW_HI(WINDOW_HI), .STEP_BASE(STEP_BASE),
    .STEP_GAP(STEP_GAP), .STEP_COUNT(STEP_COUNT), .WRAP_LO(WRAP_LO), .RELOAD(RELOAD)
  ) u_trip_a (
    .clk(clk), .rst(rst), .bump(pulse), .clear(clr_a), .digits(a_d)
  );

  odo_accum #(
    .DIGITS(TRIP_DIGITS), .WINDOW_HI(WINDOW_HI), .STEP_BASE(STEP_BASE),
    .STEP_GAP(STEP_GAP), .STEP_COUNT(STEP_COUNT), .WRAP_LO(WRAP_LO), .RELOAD(RELOAD)
  ) u_trip_b (
    .clk(clk), .rst(rst), .bump(pulse), .clear(clr_b), .digits(b_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      view_q <= VIEW_TOTAL;
    end else if (short_press) begin
      case (view_q)
        VIEW_TOTAL:  view_q <= VIEW_TRIP_A;
        VIEW_TRIP_A: view_q <= VIEW_TRIP_B;
        default:     view_q <= VIEW_TOTAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_digits <= '0;
    end else begin
      case (view_q)
        VIEW_TRIP_A: disp_digits <= {{FILL_W{1'b1}}, a_d};
        VIEW_TRIP_B: disp_digits <= {{FILL_W{1'b1}}, b_d};
        default:     disp_digits <= tot_d;
      endcase
    end
  end

  assign view = view_q;
endmodule

// File: rtl/odometer_chk.sv
module odometer_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          sense_n,
  input logic          short_press,
  input logic          long_press,
  input logic [DW-1:0] disp_digits,
  input logic [1:0]    view,
  input logic          tacho_out
);
  p_press_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(short_press && long_press));

  p_view_legal_r8: assert property (@(posedge clk) disable iff (rst)
    view != 2'd3);

  p_view_steps_r8: assert property (@(posedge clk) disable iff (rst)
    short_press |=> view == (($past(view) == 2'd2) ? 2'd0 : $past(view) + 2'd1));

  p_long_keeps_view_r9: assert property (@(posedge clk) disable iff (rst)
    (long_press && !short_press) |=> $stable(view));

  p_tacho_origin_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(tacho_out) |-> !$past(sense_n, 3));

  p_tacho_release_r7: assert property (@(posedge clk) disable iff (rst)
    $past(sense_n, 3) |-> !tacho_out);

  p_trip_fill_r10: assert property (@(posedge clk) disable iff (rst)
    (view != 2'd0) |=> disp_digits[DW-1:DW-8] == 8'hFF);

  for (genvar g = 0; g < DW / 4; g++) begin : g_nib
    p_nibble_legal_r4: assert property (@(posedge clk) disable iff (rst)
      (disp_digits[g*4 +: 4] <= 4'd9) || (disp_digits[g*4 +: 4] == 4'hF));
  end
endmodule

bind odometer odometer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .sense_n(sense_n), .short_press(short_press),
  .long_press(long_press), .disp_digits(disp_digits), .view(view),
  .tacho_out(tacho_out)
);

// File: tb/odometer_test.sv
`timescale 1ns/1ps
module odometer_test;
  localparam int WHI = 1, SBASE = 8, SGAP = 8, SCNT = 6, WLO = 60, RLD = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sense_n = 1'b1;
  logic        short_press = 1'b0;
  logic        long_press = 1'b0;
  logic [23:0] disp_digits;
  logic [1:0]  view;
  logic        tacho_out;

  int total = 0;
  int bad = 0;
  int rises = 0;
  bit tacho_prev = 1'b0;

  always #4 clk = ~clk;

  odometer #(
    .WINDOW_HI(WHI), .STEP_BASE(SBASE), .STEP_GAP(SGAP), .STEP_COUNT(SCNT),
    .WRAP_LO(WLO), .RELOAD(RLD)
  ) uut (
    .clk(clk), .rst(rst), .sense_n(sense_n), .short_press(short_press),
    .long_press(long_press), .disp_digits(disp_digits), .view(view),
    .tacho_out(tacho_out)
  );

  // behavioural reference
  int m_h1, m_h2, m_h3, m_skip, m_view;
  int m_ct, m_ca, m_cb, m_tot, m_a, m_b;
  bit m_tacho;
  logic [23:0] m_disp;

  function automatic logic [23:0] to_bcd(int n, int nd);
    logic [23:0] r = '0;
    for (int i = 0; i < nd; i++) begin
      r[i*4 +: 4] = 4'(n % 10);
      n = n / 10;
    end
    return r;
  endfunction

  function automatic bit is_step(int c);
    if ((c >> 8) != WHI) return 1'b0;
    for (int k = 0; k < SCNT; k++) if ((c & 255) == SBASE + k * SGAP) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int after_pulse(int c);
    int n = (c + 1) & 16'hFFFF;
    if ((n >> 8) == WHI && (n & 255) == WLO) return RLD;
    return n;
  endfunction

  always @(posedge clk) begin
    bit ev;
    if (rst) begin
      m_h1 = 1; m_h2 = 1; m_h3 = 1; m_skip = 0; m_view = 0; m_tacho = 1'b0;
      m_ct = RLD; m_ca = RLD; m_cb = RLD; m_tot = 0; m_a = 0; m_b = 0;
      m_disp = '0;
    end else begin
      m_disp = (m_view == 0) ? to_bcd(m_tot, 6)
             : (24'hFF0000 | to_bcd((m_view == 1) ? m_a : m_b, 4));
      ev = (m_h3 == 1) && (m_h2 == 0);
      if (ev) begin
        if (m_skip == 3) m_skip = 0;
        else begin m_skip++; m_tacho = 1'b1; end
      end else if (m_h2 == 1) m_tacho = 1'b0;
      m_h3 = m_h2; m_h2 = m_h1; m_h1 = int'(sense_n);
      if (ev) begin
        if (is_step((m_ct + 1) & 16'hFFFF)) m_tot = (m_tot + 1) % 1000000;
        m_ct = after_pulse(m_ct);
      end
      if (long_press && m_view == 1) begin m_ca = RLD; m_a = 0; end
      else if (ev) begin
        if (is_step((m_ca + 1) & 16'hFFFF)) m_a = (m_a + 1) % 10000;
        m_ca = after_pulse(m_ca);
      end
      if (long_press && m_view == 2) begin m_cb = RLD; m_b = 0; end
      else if (ev) begin
        if (is_step((m_cb + 1) & 16'hFFFF)) m_b = (m_b + 1) % 10000;
        m_cb = after_pulse(m_cb);
      end
      if (short_press) m_view = (m_view + 1) % 3;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R10 display vs model", 32'(disp_digits), 32'(m_disp));
      chk("R8 view vs model", 32'(view), 32'(m_view));
      chk("R6 tacho vs model", 32'(tacho_out), 32'(m_tacho));
      if (tacho_out && !tacho_prev) rises++;
      tacho_prev = tacho_out;
    end
  end

  task automatic pulse(int lo, int hi);
    sense_n = 1'b0;
    repeat (lo) @(negedge clk);
    sense_n = 1'b1;
    repeat (hi) @(negedge clk);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) pulse(2, 3);
  endtask

  task automatic press(bit lng);
    if (lng) long_press = 1'b1; else short_press = 1'b1;
    @(negedge clk);
    long_press = 1'b0; short_press = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R12 watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset digits", 32'(disp_digits), 32'h0);
    chk("R12 reset view", 32'(view), 32'h0);
    chk("R12 reset tacho", 32'(tacho_out), 32'h0);

    // R7: long low level, tacho held high, then released
    sense_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7 tacho high while low", 32'(tacho_out), 32'h1);
    sense_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 tacho low after release", 32'(tacho_out), 32'h0);

    pulses(62);
    chk("R1 held low counted once (63 pulses, no step)", 32'(disp_digits), 32'h0);
    pulses(1);
    chk("R3 first step at 64 pulses", 32'(disp_digits), 32'h000001);
    chk("R6 three of four pulses pass", 32'(rises), 32'd48);

    pulses(115);
    chk("R5 six steps per window", 32'(disp_digits), 32'h000006);
    pulses(1);
    chk("R5 reload value restarts window", 32'(disp_digits), 32'h000007);

    pulses(1856);
    chk("R4 carry across two digits", 32'(disp_digits), 32'h000103);

    press(1'b0);
    chk("R8 short press to trip A", 32'(view), 32'h1);
    chk("R10 trip A with fill", 32'(disp_digits), 32'hFF0103);
    press(1'b1);
    chk("R9 long press clears trip A", 32'(disp_digits), 32'hFF0000);
    pulses(64);
    chk("R9 trip A restarts from reload", 32'(disp_digits), 32'hFF0001);

    press(1'b0);
    chk("R8 short press to trip B", 32'(view), 32'h2);
    chk("R2 trip B counted while hidden", 32'(disp_digits), 32'hFF0108);
    press(1'b0);
    chk("R8 view wraps to total", 32'(view), 32'h0);
    chk("R2 total counts in every view", 32'(disp_digits), 32'h000108);
    press(1'b1);
    chk("R9 long press ignored in total view", 32'(disp_digits), 32'h000108);
    chk("R9 view unchanged by long press", 32'(view), 32'h0);

    // R11: clear and counted pulse on the same edge
    press(1'b0);
    sense_n = 1'b0;
    repeat (2) @(negedge clk);
    long_press = 1'b1;
    @(negedge clk);
    long_press = 1'b0;
    sense_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 clear wins over pulse", 32'(disp_digits), 32'hFF0000);
    pulses(63);
    chk("R11 coincident pulse not counted", 32'(disp_digits), 32'hFF0000);
    pulses(1);
    chk("R11 step after full window", 32'(disp_digits), 32'hFF0001);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule